// File: doc/BRIEF.md
# Descriptor Ring Pipe Engine

This block is a single one-way DMA pipe driven by a circular ring of 8-byte descriptors kept in system memory. Software programs the ring base address, turns the pipe on with a chosen direction, and hands over work by writing the byte offset that lies just past the last valid descriptor. The engine then fetches each descriptor, moves its payload in 32-bit beats between memory and a peripheral stream, and steps its own read offset by 8, returning to zero at the end of the ring.

Every descriptor has a 32-bit buffer address word followed by a word whose low half is the byte count and whose high half carries flags: an interrupt request, an end-of-transfer mark and an end-of-block mark. Completion, ring-drained and error conditions are latched in a status register behind an enable mask, and a single interrupt line reports any latched condition. Software can pause the walk, resume it at the same point, or hold the whole pipe in reset.

All data interfaces use valid/ready. A request on the memory port, and a beat on the outbound stream, stays valid with every field unchanged until ready is seen. The engine issues one memory read at a time and expects exactly one response per accepted read, at least one cycle later. The inbound stream is accepted only while the engine is waiting for a beat and is not paused.

Top module: `ring_pipe`

## Requirements
- R1: After reset the current offset (register 7), the status register (register 4) and `irq` read 0, and no memory request or outbound beat is presented.
- R2: A descriptor is read as two words at ring base plus offset: the first is the buffer address, the second holds the byte count in bits 15:0 and flags in bits 31:16. A count of N bytes moves ceil(N/4) beats at ascending word addresses starting at the buffer address.
- R3: With control bit 3 clear (memory to peripheral), each buffer word read is presented on `pout_data` in order. `pout_last` is high on the final beat of a descriptor whose flag bit 14 (end of transfer) or bit 13 (end of block) is set, and low on every other beat.
- R4: With control bit 3 set (peripheral to memory), words accepted on the inbound stream are written in order to the buffer. Memory beyond the last beat is left untouched.
- R5: Writing a byte offset to register 6 makes the engine process descriptors from its current offset up to, but not including, that offset. Register 7 returns the current offset, which steps by 8 and wraps to 0 at the ring end.
- R6: Status bits (register 4) latch only when the matching bit of register 3 is set. Bit 0 latches when a descriptor with flag bit 15 completes. Bit 5 latches when a descriptor with flag bit 14 completes. Writing 1 to a status bit clears it. `irq` is high whenever any status bit is set.
- R7: Status bit 3 latches when a completed descriptor brings the current offset equal to the posted offset.
- R8: A descriptor with a byte count of 0 moves no data, still advances the offset and still raises its requested events.
- R9: A descriptor whose count exceeds 32760 bytes sets status bit 4 and moves no data. The engine stops with the offset unchanged until the pipe is reset.
- R10: While register 2 bit 0 is 1, no new memory request is issued and no inbound beat is accepted. Clearing it resumes at the same point with no loss of data.
- R11: Writing 1 and then 0 to register 1 returns every register and the engine state to their reset values.
- R12: While control bit 1 (enable) is 0, posted work is not started. Control bit 5 (system mode) is stored and read back.
- R13: A memory request and an outbound beat each hold valid and all payload fields stable until accepted, and data is correct under any ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 control, 1 pipe reset, 2 pause, 3 event enable, 4 status, 5 ring base, 6 posted offset, 7 current offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Any status bit set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| pout_valid | output | 1 | Outbound beat valid |
| pout_ready | input | 1 | Outbound beat accepted |
| pout_data | output | 32 | Outbound beat data |
| pout_last | output | 1 | Final beat of a marked descriptor |
| pin_valid | input | 1 | Inbound beat valid |
| pin_ready | output | 1 | Inbound beat accepted |
| pin_data | input | 32 | Inbound beat data |

## Verification
The assertions assume the memory returns exactly one response per accepted read, never earlier than the next cycle, and never returns a response that was not requested. The bench memory model answers each accepted read on the following edge and writes accepted stores in place, so it stays within that assumption. The stall runs toggle `mem_req_ready` and `pout_ready` from a free-running counter, which exercises the hold-while-stalled properties. Pause, disable and reset are driven only through register writes between clock edges.

// File: rtl/ring_pipe_pkg.sv
package ring_pipe_pkg;
  localparam int DESC_BYTES = 8;
  localparam int BEAT_BYTES = 4;
  localparam int CNT_W      = 16;
  localparam int BEAT_W     = CNT_W - 1;

  // register word indices
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_RST  = 3'd1;
  localparam logic [2:0] RA_HALT = 3'd2;
  localparam logic [2:0] RA_EN   = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_BASE = 3'd5;
  localparam logic [2:0] RA_POST = 3'd6;
  localparam logic [2:0] RA_CUR  = 3'd7;

  typedef struct packed {
    logic prcsd;
    logic eot;
    logic ood;
    logic err;
  } pipe_evt_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH_A, S_WAIT_A, S_FETCH_B, S_WAIT_B, S_CHECK, S_PAUSE,
    S_M2P_RD, S_M2P_WAIT, S_M2P_PUSH, S_P2M_PULL, S_P2M_WR, S_DONE, S_ERR
  } walk_state_e;
endpackage

// File: rtl/ring_pipe_regs.sv
module ring_pipe_regs
  import ring_pipe_pkg::*;
#(
  parameter int OFS_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             irq,
  output logic             soft_clr,
  output logic             enable,
  output logic             dir_p2m,
  output logic             halt,
  output logic [31:0]      ring_base,
  output logic [OFS_W-1:0] post_ofs,
  input  logic [OFS_W-1:0] rd_ofs,
  input  pipe_evt_t        evt
);
  logic             rst_hold;
  logic [5:0]       ctrl_q, en_q, stat_q, stat_n;
  logic             halt_q;
  logic [31:0]      base_q;
  logic [OFS_W-1:0] post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_hold <= 1'b0;
    else if (wr_en && addr == RA_RST) rst_hold <= wdata[0];
  end

  always_comb begin
    stat_n = stat_q;
    if (wr_en && addr == RA_STAT) stat_n = stat_n & ~wdata[5:0];
    if (evt.prcsd && en_q[0]) stat_n[0] = 1'b1;
    if (evt.ood   && en_q[3]) stat_n[3] = 1'b1;
    if (evt.err   && en_q[4]) stat_n[4] = 1'b1;
    if (evt.eot   && en_q[5]) stat_n[5] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; en_q <= '0; stat_q <= '0; halt_q <= 1'b0;
      base_q <= '0; post_q <= '0;
    end else if (rst_hold) begin
      ctrl_q <= '0; en_q <= '0; stat_q <= '0; halt_q <= 1'b0;
      base_q <= '0; post_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_en) begin
        case (addr)
          RA_CTRL: ctrl_q <= wdata[5:0] & 6'b101010;
          RA_HALT: halt_q <= wdata[0];
          RA_EN:   en_q   <= wdata[5:0];
          RA_BASE: base_q <= {wdata[31:3], 3'b000};
          RA_POST: post_q <= {wdata[OFS_W-1:3], 3'b000};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = {26'd0, ctrl_q};
      RA_RST:  rdata = {31'd0, rst_hold};
      RA_HALT: rdata = {31'd0, halt_q};
      RA_EN:   rdata = {26'd0, en_q};
      RA_STAT: rdata = {26'd0, stat_q};
      RA_BASE: rdata = base_q;
      RA_POST: rdata = 32'(post_q);
      default: rdata = 32'(rd_ofs);
    endcase
  end

  assign irq       = |stat_q;
  assign soft_clr  = rst_hold;
  assign enable    = ctrl_q[1];
  assign dir_p2m   = ctrl_q[3];
  assign halt      = halt_q;
  assign ring_base = base_q;
  assign post_ofs  = post_q;

  // R6: a masked-off completion bit can never latch
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] && !stat_q[0]) |=> !stat_q[0]);
  // R11: holding the pipe reset clears offset and status one edge later
  assert_softrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> (rd_ofs == '0 && stat_q == '0));
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import ring_pipe_pkg::*;
#(
  parameter int RING_BYTES = 32768,
  parameter int MAX_XFER   = 32760,
  parameter int OFS_W      = $clog2(RING_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             enable,
  input  logic             dir_p2m,
  input  logic             halt,
  input  logic [31:0]      ring_base,
  input  logic [OFS_W-1:0] post_ofs,
  output logic [OFS_W-1:0] rd_ofs,
  output pipe_evt_t        evt,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [31:0]      mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             pout_valid,
  input  logic             pout_ready,
  output logic [31:0]      pout_data,
  output logic             pout_last,
  input  logic             pin_valid,
  output logic             pin_ready,
  input  logic [31:0]      pin_data
);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(RING_BYTES - DESC_BYTES);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_XFER);

  walk_state_e       state, ret_q;
  logic [31:0]       buf_addr, data_q, desc_addr;
  logic [CNT_W-1:0]  count_q;
  logic [BEAT_W-1:0] beats, beats_calc;
  logic [CNT_W:0]    cnt_rnd;
  logic              fl_int, fl_eot, fl_eob;
  logic [OFS_W-1:0]  nxt_ofs;
  logic              too_big;

  assign desc_addr  = ring_base + 32'(rd_ofs);
  assign nxt_ofs    = (rd_ofs == LAST_OFS) ? '0 : rd_ofs + OFS_W'(DESC_BYTES);
  assign cnt_rnd    = {1'b0, count_q} + (CNT_W+1)'(BEAT_BYTES - 1);
  assign beats_calc = cnt_rnd[CNT_W:2];
  assign too_big    = count_q > MAX_CNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ret_q <= S_IDLE; rd_ofs <= '0; buf_addr <= '0;
      data_q <= '0; count_q <= '0; beats <= '0;
      fl_int <= 1'b0; fl_eot <= 1'b0; fl_eob <= 1'b0;
    end else if (soft_clr) begin
      state <= S_IDLE; ret_q <= S_IDLE; rd_ofs <= '0; buf_addr <= '0;
      data_q <= '0; count_q <= '0; beats <= '0;
      fl_int <= 1'b0; fl_eot <= 1'b0; fl_eob <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (enable && rd_ofs != post_ofs && !halt) state <= S_FETCH_A;
        S_FETCH_A:
          if (mem_req_ready) state <= S_WAIT_A;
        S_WAIT_A:
          if (mem_rsp_valid) begin
            buf_addr <= mem_rsp_data;
            if (halt) begin state <= S_PAUSE; ret_q <= S_FETCH_B; end
            else state <= S_FETCH_B;
          end
        S_FETCH_B:
          if (mem_req_ready) state <= S_WAIT_B;
        S_WAIT_B:
          if (mem_rsp_valid) begin
            count_q <= mem_rsp_data[CNT_W-1:0];
            fl_int  <= mem_rsp_data[31];
            fl_eot  <= mem_rsp_data[30];
            fl_eob  <= mem_rsp_data[29];
            state   <= S_CHECK;
          end
        S_CHECK:
          if (too_big) state <= S_ERR;
          else if (beats_calc == '0) state <= S_DONE;
          else begin
            beats <= beats_calc;
            if (dir_p2m) state <= S_P2M_PULL;
            else if (halt) begin state <= S_PAUSE; ret_q <= S_M2P_RD; end
            else state <= S_M2P_RD;
          end
        S_PAUSE:
          if (!halt) state <= ret_q;
        S_M2P_RD:
          if (mem_req_ready) state <= S_M2P_WAIT;
        S_M2P_WAIT:
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            state  <= S_M2P_PUSH;
          end
        S_M2P_PUSH:
          if (pout_ready) begin
            buf_addr <= buf_addr + 32'(BEAT_BYTES);
            beats    <= beats - 1'b1;
            if (beats == BEAT_W'(1)) state <= S_DONE;
            else if (halt) begin state <= S_PAUSE; ret_q <= S_M2P_RD; end
            else state <= S_M2P_RD;
          end
        S_P2M_PULL:
          if (pin_valid && !halt) begin
            data_q <= pin_data;
            state  <= S_P2M_WR;
          end
        S_P2M_WR:
          if (mem_req_ready) begin
            buf_addr <= buf_addr + 32'(BEAT_BYTES);
            beats    <= beats - 1'b1;
            state    <= (beats == BEAT_W'(1)) ? S_DONE : S_P2M_PULL;
          end
        S_DONE: begin
          rd_ofs <= nxt_ofs;
          state  <= S_IDLE;
        end
        default: state <= S_ERR;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state == S_FETCH_A) || (state == S_FETCH_B) ||
                    (state == S_M2P_RD)  || (state == S_P2M_WR);
    mem_req_we    = (state == S_P2M_WR);
    mem_req_wdata = data_q;
    case (state)
      S_FETCH_A: mem_req_addr = desc_addr;
      S_FETCH_B: mem_req_addr = desc_addr + 32'(BEAT_BYTES);
      default:   mem_req_addr = buf_addr;
    endcase
  end

  assign pout_valid = (state == S_M2P_PUSH);
  assign pout_data  = data_q;
  assign pout_last  = pout_valid && beats == BEAT_W'(1) && (fl_eot || fl_eob);
  assign pin_ready  = (state == S_P2M_PULL) && !halt;

  assign evt.prcsd = (state == S_DONE) && fl_int;
  assign evt.eot   = (state == S_DONE) && fl_eot;
  assign evt.ood   = (state == S_DONE) && (nxt_ofs == post_ofs);
  assign evt.err   = (state == S_CHECK) && too_big;

  // R13: memory request holds until accepted
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
     $stable(mem_req_we) && $stable(mem_req_wdata)));
  // R13: outbound beat holds until accepted
  assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data) && $stable(pout_last)));
  // R10: no new memory request starts while paused
  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    (halt && !mem_req_valid) |=> !mem_req_valid);
  // R9: an oversize descriptor stops all traffic
  assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    evt.err |=> (!mem_req_valid && !pout_valid && !pin_ready && $stable(rd_ofs)));
  // R3/R4: only one stream direction is active at a time
  assert_one_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pout_valid && pin_ready));
endmodule

// File: rtl/ring_pipe.sv
module ring_pipe
  import ring_pipe_pkg::*;
#(
  parameter int RING_BYTES = 32768,
  parameter int MAX_XFER   = 32760
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        pout_valid,
  input  logic        pout_ready,
  output logic [31:0] pout_data,
  output logic        pout_last,
  input  logic        pin_valid,
  output logic        pin_ready,
  input  logic [31:0] pin_data
);
  localparam int OFS_W = $clog2(RING_BYTES);

  logic             soft_clr, enable, dir_p2m, halt;
  logic [31:0]      ring_base;
  logic [OFS_W-1:0] post_ofs, rd_ofs;
  pipe_evt_t        evt;

  ring_pipe_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .irq(irq), .soft_clr(soft_clr),
    .enable(enable), .dir_p2m(dir_p2m), .halt(halt), .ring_base(ring_base),
    .post_ofs(post_ofs), .rd_ofs(rd_ofs), .evt(evt)
  );

  ring_walker #(.RING_BYTES(RING_BYTES), .MAX_XFER(MAX_XFER), .OFS_W(OFS_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .enable(enable),
    .dir_p2m(dir_p2m), .halt(halt), .ring_base(ring_base), .post_ofs(post_ofs),
    .rd_ofs(rd_ofs), .evt(evt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .pout_valid(pout_valid),
    .pout_ready(pout_ready), .pout_data(pout_data), .pout_last(pout_last),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_data(pin_data)
  );
endmodule

// File: tb/ring_pipe_tb.sv
module ring_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready, pout_ready;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        pout_valid, pout_last, pin_ready;
  logic [31:0] pout_data;
  logic        pin_valid;
  logic [31:0] pin_data;

  logic [31:0] mem [0:1023];
  logic        bk_we = 1'b0;
  logic [9:0]  bk_a = '0;
  logic [31:0] bk_d = '0;
  logic        stall_en = 1'b0;
  logic [3:0]  stall_cnt = '0;
  logic [31:0] sink_d [0:63];
  logic        sink_l [0:63];
  int          sink_n = 0;
  logic [31:0] src [0:15];
  int          src_idx = 0;
  int          src_lim = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  ring_pipe #(.RING_BYTES(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .pout_valid(pout_valid),
    .pout_ready(pout_ready), .pout_data(pout_data), .pout_last(pout_last),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_data(pin_data)
  );

  assign mem_req_ready = !stall_en || stall_cnt[0];
  assign pout_ready    = !stall_en || stall_cnt[1];
  assign pin_valid     = src_idx < src_lim;
  assign pin_data      = src[src_idx[3:0]];

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    stall_cnt <= stall_cnt + 1'b1;
    if (bk_we) mem[bk_a] <= bk_d;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[11:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[11:2]];
      end
    end
    if (pout_valid && pout_ready) begin
      sink_d[sink_n[5:0]] <= pout_data;
      sink_l[sink_n[5:0]] <= pout_last;
      sink_n <= sink_n + 1;
    end
    if (pin_valid && pin_ready) src_idx <= src_idx + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic bkw(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_a = byte_addr[11:2]; bk_d = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] a, input logic [15:0] cnt,
                          input logic [15:0] flg);
    bkw(32'h100 + 32'(slot * 8), a);
    bkw(32'h104 + 32'(slot * 8), {flg, cnt});
  endtask

  task automatic wait_ofs(input logic [31:0] exp);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(3'd7, v);
      if (v == exp) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setup_pipe();
    wr(3'd5, 32'h100);
    wr(3'd3, 32'h3F);
    wr(3'd0, 32'h22);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd7, v); check("R1 cur offset", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 no request", {31'd0, mem_req_valid}, 0);
    check("R1 no beat", {31'd0, pout_valid}, 0);
  endtask

  task automatic t_m2p();
    logic [31:0] v;
    int b;
    for (int i = 0; i < 3; i++) bkw(32'h400 + 32'(4 * i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 2; i++) bkw(32'h500 + 32'(4 * i), 32'hB000_0000 + 32'(i));
    put_desc(0, 32'h400, 16'd12, 16'hC000);
    put_desc(1, 32'h500, 16'd5, 16'h2000);
    b = sink_n;
    wr(3'd6, 32'd16);
    wait_ofs(32'd16);
    check("R2 beat count ceil", 32'(sink_n - b), 5);
    for (int i = 0; i < 3; i++) check("R3 data order", sink_d[b + i], 32'hA000_0000 + 32'(i));
    check("R2 second buffer", sink_d[b + 3], 32'hB000_0000);
    check("R2 second buffer tail", sink_d[b + 4], 32'hB000_0001);
    check("R3 last on eot", {31'd0, sink_l[b + 2]}, 1);
    check("R3 no last mid", {31'd0, sink_l[b + 0]}, 0);
    check("R3 last on eob", {31'd0, sink_l[b + 4]}, 1);
    check("R3 no last before eob", {31'd0, sink_l[b + 3]}, 0);
    rd(3'd7, v); check("R5 cur offset", v, 16);
    rd(3'd4, v); check("R6 R7 status bits", v, 32'h29);
    check("R6 irq set", {31'd0, irq}, 1);
    wr(3'd4, 32'h3F);
    rd(3'd4, v); check("R6 w1c", v, 0);
    check("R6 irq clear", {31'd0, irq}, 0);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    int b;
    stall_en = 1'b1;
    put_desc(2, 32'h400, 16'd8, 16'h0000);
    b = sink_n;
    wr(3'd6, 32'd24);
    wait_ofs(32'd24);
    check("R13 stalled count", 32'(sink_n - b), 2);
    check("R13 stalled beat0", sink_d[b], 32'hA000_0000);
    check("R13 stalled beat1", sink_d[b + 1], 32'hA000_0001);
    rd(3'd4, v); check("R7 drained only", v, 32'h08);
    wr(3'd4, 32'h3F);
    stall_en = 1'b0;
  endtask

  task automatic t_p2m();
    logic [31:0] v;
    bkw(32'h610, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) src[src_lim + i] = 32'hC000_0000 + 32'(i);
    src_lim = src_lim + 4;
    wr(3'd0, 32'h2A);
    put_desc(3, 32'h600, 16'd13, 16'h8000);
    wr(3'd6, 32'd32);
    wait_ofs(32'd32);
    for (int i = 0; i < 4; i++) check("R4 written word", mem[10'h180 + 10'(i)], 32'hC000_0000 + 32'(i));
    check("R4 beyond untouched", mem[10'h184], 32'hDEAD_BEEF);
    rd(3'd4, v); check("R4 status", v, 32'h09);
    wr(3'd4, 32'h3F);
    wr(3'd0, 32'h22);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int b;
    put_desc(4, 32'h400, 16'd0, 16'h8000);
    b = sink_n;
    wr(3'd6, 32'd40);
    wait_ofs(32'd40);
    check("R8 no beats", 32'(sink_n - b), 0);
    rd(3'd7, v); check("R8 offset advanced", v, 40);
    rd(3'd4, v); check("R8 events", v, 32'h09);
    wr(3'd4, 32'h3F);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd3, 32'h38);
    put_desc(5, 32'h400, 16'd4, 16'hC000);
    wr(3'd6, 32'd48);
    wait_ofs(32'd48);
    rd(3'd4, v); check("R6 masked bit0", v, 32'h28);
    wr(3'd4, 32'h3F);
    wr(3'd3, 32'h3F);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    int b;
    wr(3'd2, 32'd1);
    put_desc(6, 32'h500, 16'd4, 16'h0000);
    b = sink_n;
    wr(3'd6, 32'd56);
    repeat (30) @(negedge clk);
    rd(3'd7, v); check("R10 paused offset", v, 48);
    check("R10 paused beats", 32'(sink_n - b), 0);
    check("R10 no request", {31'd0, mem_req_valid}, 0);
    wr(3'd2, 32'd0);
    wait_ofs(32'd56);
    check("R10 resumed beats", 32'(sink_n - b), 1);
    check("R10 resumed data", sink_d[b], 32'hB000_0000);
    wr(3'd4, 32'h3F);
  endtask

  task automatic t_enable_wrap();
    logic [31:0] v;
    int b;
    wr(3'd0, 32'h20);
    rd(3'd0, v); check("R12 sys mode readback", v, 32'h20);
    put_desc(7, 32'h400, 16'd4, 16'h0000);
    b = sink_n;
    wr(3'd6, 32'd0);
    repeat (30) @(negedge clk);
    rd(3'd7, v); check("R12 disabled offset", v, 56);
    check("R12 disabled beats", 32'(sink_n - b), 0);
    wr(3'd0, 32'h22);
    wait_ofs(32'd0);
    rd(3'd7, v); check("R5 wrap to zero", v, 0);
    check("R5 wrap beat", sink_d[b], 32'hA000_0000);
    put_desc(0, 32'h500, 16'd8, 16'h0000);
    b = sink_n;
    wr(3'd6, 32'd8);
    wait_ofs(32'd8);
    check("R5 slot reuse count", 32'(sink_n - b), 2);
    check("R5 slot reuse data", sink_d[b + 1], 32'hB000_0001);
    wr(3'd4, 32'h3F);
  endtask

  task automatic t_err();
    logic [31:0] v;
    int b;
    put_desc(1, 32'h400, 16'd32761, 16'h0000);
    b = sink_n;
    wr(3'd6, 32'd16);
    repeat (40) @(negedge clk);
    rd(3'd7, v); check("R9 offset held", v, 8);
    rd(3'd4, v); check("R9 error bit", v, 32'h10);
    check("R9 no beats", 32'(sink_n - b), 0);
    check("R9 no request", {31'd0, mem_req_valid}, 0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    int b;
    wr(3'd1, 32'd1);
    rd(3'd1, v); check("R11 reset reg held", v, 1);
    wr(3'd1, 32'd0);
    rd(3'd7, v); check("R11 offset", v, 0);
    rd(3'd4, v); check("R11 status", v, 0);
    rd(3'd0, v); check("R11 control", v, 0);
    rd(3'd5, v); check("R11 base", v, 0);
    rd(3'd6, v); check("R11 posted", v, 0);
    check("R11 irq", {31'd0, irq}, 0);
    setup_pipe();
    b = sink_n;
    wr(3'd6, 32'd8);
    wait_ofs(32'd8);
    check("R11 runs after reset", 32'(sink_n - b), 2);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    repeat (149000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) src[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    setup_pipe();
    t_m2p();
    t_stall();
    t_p2m();
    t_zero();
    t_mask();
    t_halt();
    t_enable_wrap();
    t_err();
    t_soft();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule